// File: doc/BRIEF.md
# Register-Fetch Operand Forwarding Selector

This block sits beside the register-fetch stage of a five-stage in-order pipeline (fetch, register fetch, ALU, memory, write-back). It finds the two source register numbers of the instruction being decoded and compares each one with the destination of the instructions now in the ALU, memory and write-back stages. Where an older instruction will write a register that the current instruction reads, the block delivers that in-flight result in place of the stale register-file word.

Each stage supplies a destination number and a write qualifier. Each stage also supplies the values needed to rebuild what that stage will finally write. In the ALU and memory stages this is either the computed result or the saved return address (PC+4) of a branch or jump. In the write-back stage it is either that carried value or the data read from memory, which is the same choice the register-file write port makes. The block is purely combinational. It returns the two chosen operands and a 2-bit code for each that names the source it used.

Register 31 is the constant-zero register. It is never forwarded, and any stage that does not write is treated as if it targets register 31.

Top module: `operand_bypass`

## Requirements
- R1: When neither source register matches a qualified in-flight destination, the operand equals its register-file read port (`rf_rd1` for A, `rf_rd2` for B) and its select code is 0.
- R2: A match against the ALU stage wins over every other source. It gives select code 1 and the ALU-stage value.
- R3: A match against the memory stage, with no ALU-stage match, gives select code 2 and the memory-stage value.
- R4: A match against the write-back stage only gives select code 3. The value is `wb_rdata` when `wb_from_mem` is 1, and `wb_y` otherwise.
- R5: A source register number of 31 always gives select code 0 and the register-file word, even when a stage names register 31 with its write qualifier set.
- R6: A stage whose write qualifier is 0 never matches, whatever its destination number.
- R7: When `alu_link` (or `mem_link`) is 1, the value forwarded from that stage is `alu_pc4` (`mem_pc4`) and not `alu_y` (`mem_y`).
- R8: Operand A's register number is `rf_instr[20:16]`. Operand B's register number is `rf_instr[15:11]`, or `rf_instr[25:21]` when `rf_b_from_rc` is 1.
- R9: The two operands are selected independently. One operand can forward from a stage while the other reads the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rf_instr | input | 32 | Instruction in the register-fetch stage |
| rf_b_from_rc | input | 1 | Take operand B's register number from bits 25:21 |
| rf_rd1 | input | 32 | Register-file read data for operand A |
| rf_rd2 | input | 32 | Register-file read data for operand B |
| alu_rc | input | 5 | ALU-stage destination register |
| alu_we | input | 1 | ALU-stage instruction writes the register file |
| alu_link | input | 1 | ALU-stage instruction is a branch or jump |
| alu_y | input | 32 | ALU-stage computed result |
| alu_pc4 | input | 32 | ALU-stage PC+4 |
| mem_rc | input | 5 | Memory-stage destination register |
| mem_we | input | 1 | Memory-stage instruction writes the register file |
| mem_link | input | 1 | Memory-stage instruction is a branch or jump |
| mem_y | input | 32 | Memory-stage carried result |
| mem_pc4 | input | 32 | Memory-stage PC+4 |
| wb_rc | input | 5 | Write-back destination register |
| wb_we | input | 1 | Write-back instruction writes the register file |
| wb_from_mem | input | 1 | Write-back data comes from memory read data |
| wb_y | input | 32 | Write-back carried ALU/PC value |
| wb_rdata | input | 32 | Write-back memory read data |
| opnd_a | output | 32 | Selected operand A |
| opnd_b | output | 32 | Selected operand B |
| sel_a | output | 2 | Operand A source: 0 reg file, 1 ALU, 2 MEM, 3 WB |
| sel_b | output | 2 | Operand B source: 0 reg file, 1 ALU, 2 MEM, 3 WB |

## Verification
The hardest case to reach is a register named by all three stages at once, with write qualifiers and link flags mixed. Only then does priority decide the result. In a running pipeline this needs three back-to-back writers of one register followed by a reader. The bench drives every stage directly instead. It sweeps all eight match masks against all eight write-qualifier masks, both link flags and both write-back sources. Each combination is tried for several source numbers, including 31, so the case where register 31 is named by every stage is covered in the same sweep.

// File: rtl/operand_bypass_pkg.sv
package operand_bypass_pkg;
   // Source codes returned on the select outputs; order encodes priority value
   typedef enum logic [1:0] {
      SRC_REGFILE = 2'd0,
      SRC_ALU     = 2'd1,
      SRC_MEM     = 2'd2,
      SRC_WB      = 2'd3
   } fwd_src_e;

   localparam int unsigned FWD_STAGES = 3;
   localparam int unsigned SEL_W      = 2;
endpackage

// File: rtl/bypass_dest_qual.sv
module bypass_dest_qual #(
   parameter int unsigned REG_W    = 5,
   parameter int unsigned ZERO_REG = 31
) (
   input  logic             wr_en,
   input  logic [REG_W-1:0] dest_in,
   output logic [REG_W-1:0] dest_out
);
   localparam logic [REG_W-1:0] ZERO_IDX = REG_W'(ZERO_REG);

   // A stage that does not write is steered to the zero register
   always_comb dest_out = wr_en ? dest_in : ZERO_IDX;
endmodule

// File: rtl/bypass_pick2.sv
module bypass_pick2 #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              pick_alt,
   input  logic [DATA_W-1:0] base_val,
   input  logic [DATA_W-1:0] alt_val,
   output logic [DATA_W-1:0] out_val
);
   always_comb out_val = pick_alt ? alt_val : base_val;
endmodule

// File: rtl/bypass_operand_sel.sv
module bypass_operand_sel
   import operand_bypass_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned REG_W    = 5,
   parameter int unsigned ZERO_REG = 31
) (
   input  logic [REG_W-1:0]  src_reg,
   input  logic [REG_W-1:0]  dest_alu,
   input  logic [REG_W-1:0]  dest_mem,
   input  logic [REG_W-1:0]  dest_wb,
   input  logic [DATA_W-1:0] rf_val,
   input  logic [DATA_W-1:0] alu_val,
   input  logic [DATA_W-1:0] mem_val,
   input  logic [DATA_W-1:0] wb_val,
   output logic [DATA_W-1:0] opnd,
   output logic [SEL_W-1:0]  sel
);
   localparam logic [REG_W-1:0] ZERO_IDX = REG_W'(ZERO_REG);

   logic [REG_W-1:0]  dest_arr [FWD_STAGES];
   logic [DATA_W-1:0] val_arr  [FWD_STAGES];
   logic [FWD_STAGES-1:0] hit;

   always_comb begin
      dest_arr[0] = dest_alu;
      dest_arr[1] = dest_mem;
      dest_arr[2] = dest_wb;
      val_arr[0]  = alu_val;
      val_arr[1]  = mem_val;
      val_arr[2]  = wb_val;
   end

   genvar g;
   generate
      for (g = 0; g < FWD_STAGES; g++) begin : g_cmp
         assign hit[g] = (src_reg != ZERO_IDX) && (src_reg == dest_arr[g]);
      end
   endgenerate

   // Walk from oldest stage to youngest so the youngest match overrides
   always_comb begin
      opnd = rf_val;
      sel  = SRC_REGFILE;
      for (int k = FWD_STAGES - 1; k >= 0; k--) begin
         if (hit[k]) begin
            opnd = val_arr[k];
            sel  = SEL_W'(k + 1);
         end
      end
   end
endmodule

// File: rtl/operand_bypass.sv
module operand_bypass
   import operand_bypass_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned INSTR_W  = 32,
   parameter int unsigned REG_W    = 5,
   parameter int unsigned ZERO_REG = 31,
   parameter int unsigned RA_LSB   = 16,
   parameter int unsigned RB_LSB   = 11,
   parameter int unsigned RC_LSB   = 21
) (
   input  logic [INSTR_W-1:0] rf_instr,
   input  logic               rf_b_from_rc,
   input  logic [DATA_W-1:0]  rf_rd1,
   input  logic [DATA_W-1:0]  rf_rd2,
   input  logic [REG_W-1:0]   alu_rc,
   input  logic               alu_we,
   input  logic               alu_link,
   input  logic [DATA_W-1:0]  alu_y,
   input  logic [DATA_W-1:0]  alu_pc4,
   input  logic [REG_W-1:0]   mem_rc,
   input  logic               mem_we,
   input  logic               mem_link,
   input  logic [DATA_W-1:0]  mem_y,
   input  logic [DATA_W-1:0]  mem_pc4,
   input  logic [REG_W-1:0]   wb_rc,
   input  logic               wb_we,
   input  logic               wb_from_mem,
   input  logic [DATA_W-1:0]  wb_y,
   input  logic [DATA_W-1:0]  wb_rdata,
   output logic [DATA_W-1:0]  opnd_a,
   output logic [DATA_W-1:0]  opnd_b,
   output logic [1:0]         sel_a,
   output logic [1:0]         sel_b
);
   localparam int unsigned N_OPND = 2;

   initial begin
      assert (ZERO_REG < (1 << REG_W))
         else $error("ZERO_REG does not fit in REG_W bits");
      assert (RA_LSB + REG_W <= INSTR_W && RB_LSB + REG_W <= INSTR_W
              && RC_LSB + REG_W <= INSTR_W)
         else $error("register field lies outside the instruction");
      assert (DATA_W > 0) else $error("DATA_W must be positive");
   end

   // Qualified destinations, one per forwarding stage
   logic [REG_W-1:0] q_alu, q_mem, q_wb;
   logic [REG_W-1:0] stage_rc [FWD_STAGES];
   logic             stage_we [FWD_STAGES];
   logic [REG_W-1:0] stage_q  [FWD_STAGES];

   always_comb begin
      stage_rc[0] = alu_rc;  stage_we[0] = alu_we;
      stage_rc[1] = mem_rc;  stage_we[1] = mem_we;
      stage_rc[2] = wb_rc;   stage_we[2] = wb_we;
   end

   genvar s;
   generate
      for (s = 0; s < FWD_STAGES; s++) begin : g_qual
         bypass_dest_qual #(.REG_W(REG_W), .ZERO_REG(ZERO_REG)) i_qual (
            .wr_en   (stage_we[s]),
            .dest_in (stage_rc[s]),
            .dest_out(stage_q[s])
         );
      end
   endgenerate

   assign q_alu = stage_q[0];
   assign q_mem = stage_q[1];
   assign q_wb  = stage_q[2];

   // Rebuild the value each stage will eventually write
   logic [DATA_W-1:0] v_alu, v_mem, v_wb;

   bypass_pick2 #(.DATA_W(DATA_W)) i_pick_alu (
      .pick_alt(alu_link), .base_val(alu_y), .alt_val(alu_pc4), .out_val(v_alu));
   bypass_pick2 #(.DATA_W(DATA_W)) i_pick_mem (
      .pick_alt(mem_link), .base_val(mem_y), .alt_val(mem_pc4), .out_val(v_mem));
   bypass_pick2 #(.DATA_W(DATA_W)) i_pick_wb (
      .pick_alt(wb_from_mem), .base_val(wb_y), .alt_val(wb_rdata), .out_val(v_wb));

   // Source register numbers
   logic [REG_W-1:0] src_a, src_b;
   always_comb begin
      src_a = rf_instr[RA_LSB +: REG_W];
      src_b = rf_b_from_rc ? rf_instr[RC_LSB +: REG_W] : rf_instr[RB_LSB +: REG_W];
   end

   logic [REG_W-1:0]  op_src [N_OPND];
   logic [DATA_W-1:0] op_rf  [N_OPND];
   logic [DATA_W-1:0] op_out [N_OPND];
   logic [SEL_W-1:0]  op_sel [N_OPND];

   always_comb begin
      op_src[0] = src_a;  op_rf[0] = rf_rd1;
      op_src[1] = src_b;  op_rf[1] = rf_rd2;
   end

   genvar o;
   generate
      for (o = 0; o < N_OPND; o++) begin : g_opnd
         bypass_operand_sel #(
            .DATA_W(DATA_W), .REG_W(REG_W), .ZERO_REG(ZERO_REG)
         ) i_sel (
            .src_reg (op_src[o]),
            .dest_alu(q_alu),
            .dest_mem(q_mem),
            .dest_wb (q_wb),
            .rf_val  (op_rf[o]),
            .alu_val (v_alu),
            .mem_val (v_mem),
            .wb_val  (v_wb),
            .opnd    (op_out[o]),
            .sel     (op_sel[o])
         );
      end
   endgenerate

   assign opnd_a = op_out[0];
   assign opnd_b = op_out[1];
   assign sel_a  = op_sel[0];
   assign sel_b  = op_sel[1];
endmodule

// File: rtl/operand_bypass_chk.sv
module operand_bypass_chk #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned INSTR_W  = 32,
   parameter int unsigned REG_W    = 5,
   parameter int unsigned ZERO_REG = 31,
   parameter int unsigned RA_LSB   = 16,
   parameter int unsigned RB_LSB   = 11,
   parameter int unsigned RC_LSB   = 21
) (
   input logic [INSTR_W-1:0] rf_instr,
   input logic               rf_b_from_rc,
   input logic [DATA_W-1:0]  rf_rd1,
   input logic [DATA_W-1:0]  rf_rd2,
   input logic [REG_W-1:0]   alu_rc,
   input logic               alu_we,
   input logic               alu_link,
   input logic [DATA_W-1:0]  alu_y,
   input logic [DATA_W-1:0]  alu_pc4,
   input logic [REG_W-1:0]   mem_rc,
   input logic               mem_we,
   input logic [DATA_W-1:0]  wb_y,
   input logic [DATA_W-1:0]  wb_rdata,
   input logic               wb_from_mem,
   input logic [DATA_W-1:0]  opnd_a,
   input logic [DATA_W-1:0]  opnd_b,
   input logic [1:0]         sel_a,
   input logic [1:0]         sel_b
);
   logic [REG_W-1:0] ra, rb_eff;
   always_comb begin
      ra     = rf_instr[RA_LSB +: REG_W];
      rb_eff = rf_b_from_rc ? rf_instr[RC_LSB +: REG_W] : rf_instr[RB_LSB +: REG_W];
   end

   always_comb begin
      // R5
      zero_src_a_chk: assert (ra != REG_W'(ZERO_REG) || sel_a == 2'd0);
      // R5
      zero_src_b_chk: assert (rb_eff != REG_W'(ZERO_REG) || sel_b == 2'd0);
      // R1
      rf_data_a_chk: assert (sel_a != 2'd0 || opnd_a == rf_rd1);
      // R1
      rf_data_b_chk: assert (sel_b != 2'd0 || opnd_b == rf_rd2);
      // R2 R6
      alu_hit_a_chk: assert (sel_a != 2'd1 || (alu_we && alu_rc == ra));
      // R2
      alu_prio_a_chk: assert (!(alu_we && alu_rc == ra && ra != REG_W'(ZERO_REG))
                              || sel_a == 2'd1);
      // R3 R6
      mem_hit_b_chk: assert (sel_b != 2'd2 || (mem_we && mem_rc == rb_eff));
      // R7
      alu_link_a_chk: assert (sel_a != 2'd1 || opnd_a == (alu_link ? alu_pc4 : alu_y));
      // R4
      wb_val_a_chk: assert (sel_a != 2'd3 || opnd_a == (wb_from_mem ? wb_rdata : wb_y));
   end
endmodule

bind operand_bypass operand_bypass_chk #(
   .DATA_W(DATA_W), .INSTR_W(INSTR_W), .REG_W(REG_W), .ZERO_REG(ZERO_REG),
   .RA_LSB(RA_LSB), .RB_LSB(RB_LSB), .RC_LSB(RC_LSB)
) i_operand_bypass_chk (
   .rf_instr(rf_instr), .rf_b_from_rc(rf_b_from_rc),
   .rf_rd1(rf_rd1), .rf_rd2(rf_rd2),
   .alu_rc(alu_rc), .alu_we(alu_we), .alu_link(alu_link),
   .alu_y(alu_y), .alu_pc4(alu_pc4),
   .mem_rc(mem_rc), .mem_we(mem_we),
   .wb_y(wb_y), .wb_rdata(wb_rdata), .wb_from_mem(wb_from_mem),
   .opnd_a(opnd_a), .opnd_b(opnd_b), .sel_a(sel_a), .sel_b(sel_b)
);

// File: tb/test_operand_bypass.sv
module test_operand_bypass;
   logic clk = 1'b0;
   always #2 clk = ~clk;  // 250 MHz

   logic [31:0] rf_instr;
   logic        rf_b_from_rc;
   logic [31:0] rf_rd1, rf_rd2;
   logic [4:0]  alu_rc, mem_rc, wb_rc;
   logic        alu_we, mem_we, wb_we, alu_link, mem_link, wb_from_mem;
   logic [31:0] alu_y, alu_pc4, mem_y, mem_pc4, wb_y, wb_rdata;
   logic [31:0] opnd_a, opnd_b;
   logic [1:0]  sel_a, sel_b;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   operand_bypass i_operand_bypass (.*);

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Expected source code from the requirements
   function automatic logic [1:0] exp_sel(logic [4:0] src);
      if (src == 5'd31) return 2'd0;
      if (alu_we && alu_rc == src) return 2'd1;
      if (mem_we && mem_rc == src) return 2'd2;
      if (wb_we && wb_rc == src) return 2'd3;
      return 2'd0;
   endfunction

   function automatic logic [31:0] exp_val(logic [1:0] s, logic [31:0] rf);
      case (s)
         2'd1:    return alu_link ? alu_pc4 : alu_y;
         2'd2:    return mem_link ? mem_pc4 : mem_y;
         2'd3:    return wb_from_mem ? wb_rdata : wb_y;
         default: return rf;
      endcase
   endfunction

   function automatic string tag(logic [1:0] s, logic [4:0] src);
      if (src == 5'd31) return "R5";
      case (s)
         2'd1:    return "R2";
         2'd2:    return "R3";
         2'd3:    return "R4";
         default: return "R1";
      endcase
   endfunction

   task automatic set_instr(logic [4:0] rc, logic [4:0] ra, logic [4:0] rb);
      rf_instr = {6'b010101, rc, ra, rb, 11'h2A5};
   endtask

   task automatic idle();
      set_instr(5'd31, 5'd0, 5'd0);
      rf_b_from_rc = 0; rf_rd1 = 32'h1111_0001; rf_rd2 = 32'h2222_0002;
      alu_rc = 0; mem_rc = 0; wb_rc = 0;
      alu_we = 0; mem_we = 0; wb_we = 0;
      alu_link = 0; mem_link = 0; wb_from_mem = 0;
      alu_y = 32'hA1A1_0000; alu_pc4 = 32'hA2A2_0004;
      mem_y = 32'hB1B1_0000; mem_pc4 = 32'hB2B2_0004;
      wb_y  = 32'hC1C1_0000; wb_rdata = 32'hC2C2_0000;
   endtask

   task automatic cmp_both(string extra);
      logic [4:0] sa, sb;
      logic [1:0] ea, eb;
      sa = rf_instr[20:16];
      sb = rf_b_from_rc ? rf_instr[25:21] : rf_instr[15:11];
      ea = exp_sel(sa);
      eb = exp_sel(sb);
      check({tag(ea, sa), extra, " sel_a"}, {30'd0, sel_a}, {30'd0, ea});
      check({tag(ea, sa), extra, " opnd_a"}, opnd_a, exp_val(ea, rf_rd1));
      check({tag(eb, sb), extra, " sel_b"}, {30'd0, sel_b}, {30'd0, eb});
      check({tag(eb, sb), extra, " opnd_b"}, opnd_b, exp_val(eb, rf_rd2));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      idle();
      @(negedge clk);
      // Quiet state: nothing qualified, both operands from register file (R1)
      check("R1 idle sel_a", {30'd0, sel_a}, 32'd0);
      check("R1 idle opnd_b", opnd_b, 32'h2222_0002);

      // R6: every stage names r7 but none writes
      set_instr(5'd0, 5'd7, 5'd7);
      alu_rc = 7; mem_rc = 7; wb_rc = 7;
      #1;
      check("R6 no-write sel_a", {30'd0, sel_a}, 32'd0);
      check("R6 no-write opnd_a", opnd_a, rf_rd1);

      // R5: every stage writes r31
      set_instr(5'd31, 5'd31, 5'd31);
      alu_rc = 31; mem_rc = 31; wb_rc = 31; alu_we = 1; mem_we = 1; wb_we = 1;
      #1;
      check("R5 zero reg sel_a", {30'd0, sel_a}, 32'd0);
      check("R5 zero reg opnd_b", opnd_b, rf_rd2);

      // R8/R9: B from Rc field; A forwards from ALU, B reads reg file
      idle();
      set_instr(5'd9, 5'd4, 5'd4);
      rf_b_from_rc = 1; alu_rc = 4; alu_we = 1;
      #1;
      check("R8 rc field sel_b", {30'd0, sel_b}, 32'd0);
      check("R9 independent sel_a", {30'd0, sel_a}, 32'd1);
      mem_rc = 9; mem_we = 1; mem_link = 1;
      #1;
      check("R8 rc field opnd_b", opnd_b, mem_pc4);
      check("R7 mem link sel_b", {30'd0, sel_b}, 32'd2);
      alu_link = 1;
      #1;
      check("R7 alu link opnd_a", opnd_a, alu_pc4);

      // Sweep: match masks x write masks x links x wb source x sources
      for (int si = 0; si < 4; si++) begin
         for (int m = 0; m < 8; m++) begin
            for (int w = 0; w < 8; w++) begin
               for (int lk = 0; lk < 8; lk++) begin
                  logic [4:0] src, other;
                  case (si)
                     0: src = 5'd0;
                     1: src = 5'd7;
                     2: src = 5'd30;
                     default: src = 5'd31;
                  endcase
                  other = src ^ 5'd1;
                  set_instr(src ^ 5'd2, src, src ^ 5'd4);
                  rf_b_from_rc = lk[2];
                  rf_rd1 = 32'h5000_0000 + 32'(m * 64 + w);
                  rf_rd2 = 32'h6000_0000 + 32'(lk * 8 + si);
                  alu_rc = m[0] ? src : other;
                  mem_rc = m[1] ? src : other;
                  wb_rc  = m[2] ? src : (lk[2] ? src ^ 5'd2 : src ^ 5'd4);
                  alu_we = w[0]; mem_we = w[1]; wb_we = w[2];
                  alu_link = lk[0]; mem_link = lk[1]; wb_from_mem = lk[2] ^ m[0];
                  alu_y   = 32'hA000_0000 + 32'(si);
                  alu_pc4 = 32'hA400_0000 + 32'(m);
                  mem_y   = 32'hB000_0000 + 32'(w);
                  mem_pc4 = 32'hB400_0000 + 32'(lk);
                  wb_y    = 32'hC000_0000 + 32'(si * 8 + w);
                  wb_rdata= 32'hC400_0000 + 32'(m * 8 + lk);
                  #1;
                  cmp_both(" sweep");
               end
            end
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule